// File: doc/BRIEF.md
# Windowed Command and Interrupt Status Port

This block is the host-side control port of a network adapter. The host writes 16-bit words to one command port. Each word holds a 5-bit opcode in bits 15:11 and an 11-bit argument in bits 10:0. The block decodes the opcode and updates its registers:

- the register-window number;
- the enable states of the receiver and transmitter;
- the receive filter;
- the interrupt mask and the status-visibility mask;
- three 11-bit threshold values.

It also issues single-cycle reset pulses to the receive and transmit engines.

Interrupt causes arrive as single-cycle event pulses from the rest of the adapter. Each pulse sets a sticky cause bit, and those bits stay set until the host acknowledges them with a mask-carrying command. A status word, read at the same offset as the command port, shows three things: the current window, a command-in-progress flag and the visible cause bits. The interrupt output follows a latch. The latch is set by any cause that the interrupt mask enables.

Top module: `hcp_ctrl_port`

## Requirements
- R1: The opcode is `cmd_data[15:11]` and the argument is `cmd_data[10:0]`. A command that takes no argument (for example opcode 4) behaves the same whatever its argument bits are.
- R2: Opcode 1 loads the window number from argument bits 2:0. The status word shows the window in bits 15:13.
- R3: After reset the receiver and transmitter are disabled. Opcode 4 enables the receiver and opcode 3 disables it. Opcode 9 enables the transmitter and opcode 10 disables it.
- R4: Opcode 5 drives `rx_rst` high and opcode 11 drives `tx_rst` high, each for exactly one cycle after the command. The enable states do not change.
- R5: A pulse on `evt_pulse` bit k sets cause bit k for k in {1,2,3,4,5,7}, where 1 = adapter failure, 2 = transmit complete, 3 = transmit available, 4 = receive complete, 5 = receive early and 7 = update statistics. Pulses on bits 0 and 6 have no effect.
- R6: Opcode 12 sets cause bit 6 (interrupt requested).
- R7: Opcode 13 clears each cause bit whose position is set in argument bits 7:0. An event on the same bit in the same cycle wins over the clear.
- R8: Opcode 14 loads the interrupt mask from argument bits 7:0. The latch (status bit 0) is set when a cause in bits 7:1 is raised while its mask bit is set. `irq` equals the latch. Only an acknowledge with argument bit 0 set, or a global reset, clears the latch.
- R9: Opcode 15 loads the visibility mask from argument bits 7:0. Status bits 7:0 show the causes ANDed with this mask.
- R10: Opcode 16 loads `rx_filter` from argument bits 3:0. Bit 0 = own address, bit 1 = multicast, bit 2 = broadcast, bit 3 = all frames.
- R11: Opcodes 17, 18 and 19 load the receive-early, transmit-available and transmit-start thresholds. `thr_off` bits 0, 1 and 2 are high while the matching threshold equals 2047.
- R12: Opcode 0 is a global reset. It returns the window, both masks, the filter, the thresholds, the causes, the latch and the enables to zero or disabled. It then holds status bit 12 (busy) high for 4 cycles. Commands written while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word: opcode 15:11, argument 10:0 |
| evt_pulse | input | 8 | One-cycle interrupt cause events, by cause position |
| status | output | 16 | Window, busy flag and visible cause bits |
| irq | output | 1 | Interrupt request (the latch) |
| rx_en | output | 1 | Receiver enabled |
| tx_en | output | 1 | Transmitter enabled |
| rx_rst | output | 1 | One-cycle receiver reset pulse |
| tx_rst | output | 1 | One-cycle transmitter reset pulse |
| rx_filter | output | 4 | Receive filter selection |
| thr_rx_early | output | 11 | Receive-early threshold |
| thr_tx_avail | output | 11 | Transmit-available threshold |
| thr_tx_start | output | 11 | Transmit-start threshold |
| thr_off | output | 3 | Threshold disabled flags (value 2047) |

## Verification
The assertions check the following on every cycle:

- a global reset leaves the enables and window cleared on the next cycle;
- a masked cause always sets the latch;
- the latch falls only after an acknowledge of bit 0 or a global reset;
- an acknowledge leaves no cleared bit standing unless an event re-raised it;
- a command during busy moves no state.

Only the bench scenarios can show:

- the exact status values produced by event, acknowledge and mask sequences;
- that event bits 0 and 6 are ignored;
- that hidden causes reappear when the visibility mask opens;
- the precise four-cycle length of busy, with the first accepted command after it.

// File: rtl/hcp_pkg.sv
// Package: shared widths, opcode values and cause positions for the
// host control port. Assumes a 16-bit command word, 5-bit opcode.
package hcp_pkg;
    localparam int CMD_W    = 16;
    localparam int OP_W     = 5;
    localparam int ARG_W    = CMD_W - OP_W;
    localparam int NCAUSE   = 8;
    localparam int WIN_W    = 3;
    localparam int FILT_W   = 4;
    localparam int NUM_THR  = 3;
    localparam int RST_CYC  = 4;
    localparam int STAT_PAD = CMD_W - WIN_W - 1 - NCAUSE;

    localparam logic [ARG_W-1:0] THR_OFF_VAL = {ARG_W{1'b1}};

    // Causes that external event pulses may set (bits 0 and 6 are internal)
    localparam logic [NCAUSE-1:0] HW_CAUSES = 8'b1011_1110;
    localparam int CAUSE_REQ = 6;

    localparam logic [OP_W-1:0] OP_GRST     = 5'd0;
    localparam logic [OP_W-1:0] OP_WIN      = 5'd1;
    localparam logic [OP_W-1:0] OP_RX_OFF   = 5'd3;
    localparam logic [OP_W-1:0] OP_RX_ON    = 5'd4;
    localparam logic [OP_W-1:0] OP_RX_RST   = 5'd5;
    localparam logic [OP_W-1:0] OP_TX_ON    = 5'd9;
    localparam logic [OP_W-1:0] OP_TX_OFF   = 5'd10;
    localparam logic [OP_W-1:0] OP_TX_RST   = 5'd11;
    localparam logic [OP_W-1:0] OP_REQ_INT  = 5'd12;
    localparam logic [OP_W-1:0] OP_ACK      = 5'd13;
    localparam logic [OP_W-1:0] OP_IMASK    = 5'd14;
    localparam logic [OP_W-1:0] OP_VMASK    = 5'd15;
    localparam logic [OP_W-1:0] OP_FILT     = 5'd16;
    localparam logic [OP_W-1:0] OP_THR_BASE = 5'd17;
endpackage

// File: rtl/hcp_cmd_decode.sv
// Command decoder: turns an accepted command write into one-hot
// strobes. Assumes busy blocks acceptance; undefined opcodes do nothing.
module hcp_cmd_decode
    import hcp_pkg::*;
(
    input  logic                 cmd_we,
    input  logic [OP_W-1:0]      opcode,
    input  logic                 busy,
    output logic                 go_grst,
    output logic                 go_win,
    output logic                 go_rx_off,
    output logic                 go_rx_on,
    output logic                 go_rx_rst,
    output logic                 go_tx_on,
    output logic                 go_tx_off,
    output logic                 go_tx_rst,
    output logic                 go_req,
    output logic                 go_ack,
    output logic                 go_imask,
    output logic                 go_vmask,
    output logic                 go_filt,
    output logic [NUM_THR-1:0]   go_thr
);
    logic accept;
    assign accept = cmd_we && !busy;

    // Purpose: map the opcode of an accepted write to its strobe
    always_comb begin
        go_grst   = 1'b0;
        go_win    = 1'b0;
        go_rx_off = 1'b0;
        go_rx_on  = 1'b0;
        go_rx_rst = 1'b0;
        go_tx_on  = 1'b0;
        go_tx_off = 1'b0;
        go_tx_rst = 1'b0;
        go_req    = 1'b0;
        go_ack    = 1'b0;
        go_imask  = 1'b0;
        go_vmask  = 1'b0;
        go_filt   = 1'b0;
        if (accept) begin
            case (opcode)
                OP_GRST:    go_grst   = 1'b1;
                OP_WIN:     go_win    = 1'b1;
                OP_RX_OFF:  go_rx_off = 1'b1;
                OP_RX_ON:   go_rx_on  = 1'b1;
                OP_RX_RST:  go_rx_rst = 1'b1;
                OP_TX_ON:   go_tx_on  = 1'b1;
                OP_TX_OFF:  go_tx_off = 1'b1;
                OP_TX_RST:  go_tx_rst = 1'b1;
                OP_REQ_INT: go_req    = 1'b1;
                OP_ACK:     go_ack    = 1'b1;
                OP_IMASK:   go_imask  = 1'b1;
                OP_VMASK:   go_vmask  = 1'b1;
                OP_FILT:    go_filt   = 1'b1;
                default:    ;
            endcase
        end
    end

    // Purpose: one strobe per threshold opcode, consecutive from the base
    for (genvar i = 0; i < NUM_THR; i++) begin : g_thr_dec
        assign go_thr[i] = accept && (opcode == OP_THR_BASE + OP_W'(i));
    end
endmodule

// File: rtl/hcp_cfg_regs.sv
// Configuration registers: window, enables, reset pulses, filter,
// masks and thresholds. Assumes strobes are mutually exclusive.
module hcp_cfg_regs
    import hcp_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ARG_W-1:0]           arg,
    input  logic                       go_grst,
    input  logic                       go_win,
    input  logic                       go_rx_off,
    input  logic                       go_rx_on,
    input  logic                       go_rx_rst,
    input  logic                       go_tx_on,
    input  logic                       go_tx_off,
    input  logic                       go_tx_rst,
    input  logic                       go_imask,
    input  logic                       go_vmask,
    input  logic                       go_filt,
    input  logic [NUM_THR-1:0]         go_thr,
    output logic [WIN_W-1:0]           window,
    output logic                       rx_en,
    output logic                       tx_en,
    output logic                       rx_rst,
    output logic                       tx_rst,
    output logic [FILT_W-1:0]          rx_filter,
    output logic [NCAUSE-1:0]          imask,
    output logic [NCAUSE-1:0]          vmask,
    output logic [NUM_THR*ARG_W-1:0]   thr_flat,
    output logic [NUM_THR-1:0]         thr_off
);
    // Purpose: window number register
    always_ff @(posedge clk) begin
        if (!rst_n || go_grst) window <= '0;
        else if (go_win)       window <= arg[WIN_W-1:0];
    end

    // Purpose: receiver and transmitter enable states
    always_ff @(posedge clk) begin
        if (!rst_n || go_grst) begin
            rx_en <= 1'b0;
            tx_en <= 1'b0;
        end else begin
            if (go_rx_on)       rx_en <= 1'b1;
            else if (go_rx_off) rx_en <= 1'b0;
            if (go_tx_on)       tx_en <= 1'b1;
            else if (go_tx_off) tx_en <= 1'b0;
        end
    end

    // Purpose: single-cycle engine reset pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_rst <= 1'b0;
            tx_rst <= 1'b0;
        end else begin
            rx_rst <= go_rx_rst;
            tx_rst <= go_tx_rst;
        end
    end

    // Purpose: receive filter and the two cause masks
    always_ff @(posedge clk) begin
        if (!rst_n || go_grst) begin
            rx_filter <= '0;
            imask     <= '0;
            vmask     <= '0;
        end else begin
            if (go_filt)  rx_filter <= arg[FILT_W-1:0];
            if (go_imask) imask     <= arg[NCAUSE-1:0];
            if (go_vmask) vmask     <= arg[NCAUSE-1:0];
        end
    end

    // Purpose: threshold registers with an all-ones disable flag each
    for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
        logic [ARG_W-1:0] thr_q;
        always_ff @(posedge clk) begin
            if (!rst_n || go_grst) thr_q <= '0;
            else if (go_thr[i])    thr_q <= arg;
        end
        assign thr_flat[i*ARG_W +: ARG_W] = thr_q;
        assign thr_off[i] = (thr_q == THR_OFF_VAL);
    end

    p_grst_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        go_grst |=> (!rx_en && !tx_en && window == '0 && imask == '0));
    p_rx_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (go_rx_on && !go_grst) |=> rx_en);
    p_rst_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rst |-> ($past(go_rx_rst) && $stable(rx_en)));
    p_thr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!go_thr[0] && !go_grst) |=> $stable(thr_flat[ARG_W-1:0]));
endmodule

// File: rtl/hcp_irq_status.sv
// Interrupt cause bits and latch. Assumes events are one-cycle pulses
// and that a new event wins over an acknowledge of the same bit.
module hcp_irq_status
    import hcp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCAUSE-1:0]  evt_pulse,
    input  logic               go_grst,
    input  logic               go_req,
    input  logic               go_ack,
    input  logic [NCAUSE-1:0]  ack_bits,
    input  logic [NCAUSE-1:0]  imask,
    output logic [NCAUSE-1:0]  cause,
    output logic               irq
);
    logic [NCAUSE-1:0] set_v;
    logic [NCAUSE-1:0] clr_v;
    logic [NCAUSE-1:1] cause_q;
    logic              latch_q;
    logic              latch_set;

    // Purpose: gather this cycle's set and clear vectors
    always_comb begin
        set_v = evt_pulse & HW_CAUSES;
        set_v[CAUSE_REQ] = go_req;
        clr_v = go_ack ? ack_bits : '0;
        latch_set = |(set_v[NCAUSE-1:1] & imask[NCAUSE-1:1]);
    end

    // Purpose: sticky cause bits, set over clear
    always_ff @(posedge clk) begin
        if (!rst_n || go_grst) cause_q <= '0;
        else cause_q <= (cause_q & ~clr_v[NCAUSE-1:1]) | set_v[NCAUSE-1:1];
    end

    // Purpose: interrupt latch, cleared only by acknowledge bit 0
    always_ff @(posedge clk) begin
        if (!rst_n || go_grst)  latch_q <= 1'b0;
        else if (latch_set)     latch_q <= 1'b1;
        else if (clr_v[0])      latch_q <= 1'b0;
    end

    assign cause = {cause_q, latch_q};
    assign irq   = latch_q;

    p_latch_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_set && !go_grst) |=> irq);
    p_latch_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latch_q) |-> ($past(go_ack && ack_bits[0]) || $past(go_grst)));
    p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (go_ack && !go_grst) |=>
        ((cause_q & $past(ack_bits[NCAUSE-1:1] & ~set_v[NCAUSE-1:1])) == '0));
    p_req_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (go_req && !go_grst) |=> cause[CAUSE_REQ]);
endmodule

// File: rtl/hcp_ctrl_port.sv
// Top: command/status port. Splits the command word, holds the busy
// counter after a global reset and assembles the status word.
// Assumes a synchronous active-low reset.
module hcp_ctrl_port
    import hcp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_we,
    input  logic [15:0]        cmd_data,
    input  logic [7:0]         evt_pulse,
    output logic [15:0]        status,
    output logic               irq,
    output logic               rx_en,
    output logic               tx_en,
    output logic               rx_rst,
    output logic               tx_rst,
    output logic [3:0]         rx_filter,
    output logic [10:0]        thr_rx_early,
    output logic [10:0]        thr_tx_avail,
    output logic [10:0]        thr_tx_start,
    output logic [2:0]         thr_off
);
    localparam int BUSY_W = $clog2(RST_CYC + 1);

    logic [OP_W-1:0]          opcode;
    logic [ARG_W-1:0]         arg;
    logic [BUSY_W-1:0]        busy_cnt;
    logic                     busy;
    logic go_grst, go_win, go_rx_off, go_rx_on, go_rx_rst;
    logic go_tx_on, go_tx_off, go_tx_rst, go_req, go_ack;
    logic go_imask, go_vmask, go_filt;
    logic [NUM_THR-1:0]       go_thr;
    logic [WIN_W-1:0]         window;
    logic [NCAUSE-1:0]        imask;
    logic [NCAUSE-1:0]        vmask;
    logic [NCAUSE-1:0]        cause;
    logic [NUM_THR*ARG_W-1:0] thr_flat;

    assign opcode = cmd_data[CMD_W-1:ARG_W];
    assign arg    = cmd_data[ARG_W-1:0];
    assign busy   = (busy_cnt != '0);

    // Purpose: count the busy window that follows a global reset
    always_ff @(posedge clk) begin
        if (!rst_n)             busy_cnt <= '0;
        else if (go_grst)       busy_cnt <= BUSY_W'(RST_CYC);
        else if (busy)          busy_cnt <= busy_cnt - 1'b1;
    end

    hcp_cmd_decode u_dec (
        .cmd_we    (cmd_we),
        .opcode    (opcode),
        .busy      (busy),
        .go_grst   (go_grst),
        .go_win    (go_win),
        .go_rx_off (go_rx_off),
        .go_rx_on  (go_rx_on),
        .go_rx_rst (go_rx_rst),
        .go_tx_on  (go_tx_on),
        .go_tx_off (go_tx_off),
        .go_tx_rst (go_tx_rst),
        .go_req    (go_req),
        .go_ack    (go_ack),
        .go_imask  (go_imask),
        .go_vmask  (go_vmask),
        .go_filt   (go_filt),
        .go_thr    (go_thr)
    );

    hcp_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .arg       (arg),
        .go_grst   (go_grst),
        .go_win    (go_win),
        .go_rx_off (go_rx_off),
        .go_rx_on  (go_rx_on),
        .go_rx_rst (go_rx_rst),
        .go_tx_on  (go_tx_on),
        .go_tx_off (go_tx_off),
        .go_tx_rst (go_tx_rst),
        .go_imask  (go_imask),
        .go_vmask  (go_vmask),
        .go_filt   (go_filt),
        .go_thr    (go_thr),
        .window    (window),
        .rx_en     (rx_en),
        .tx_en     (tx_en),
        .rx_rst    (rx_rst),
        .tx_rst    (tx_rst),
        .rx_filter (rx_filter),
        .imask     (imask),
        .vmask     (vmask),
        .thr_flat  (thr_flat),
        .thr_off   (thr_off)
    );

    hcp_irq_status u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .go_grst   (go_grst),
        .go_req    (go_req),
        .go_ack    (go_ack),
        .ack_bits  (arg[NCAUSE-1:0]),
        .imask     (imask),
        .cause     (cause),
        .irq       (irq)
    );

    assign thr_rx_early = thr_flat[0*ARG_W +: ARG_W];
    assign thr_tx_avail = thr_flat[1*ARG_W +: ARG_W];
    assign thr_tx_start = thr_flat[2*ARG_W +: ARG_W];
    assign status = {window, busy, {STAT_PAD{1'b0}}, cause & vmask};

    p_busy_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_we) |=> ($stable(rx_en) && $stable(tx_en) && $stable(rx_filter)
                              && $stable(status[15:13])));
    p_busy_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= BUSY_W'(RST_CYC));
    p_busy_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        go_grst |=> status[12]);
endmodule

// File: tb/test_hcp_ctrl_port.sv
module test_hcp_ctrl_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_data = '0;
    logic [7:0]  evt_pulse = '0;
    logic [15:0] status;
    logic        irq, rx_en, tx_en, rx_rst, tx_rst;
    logic [3:0]  rx_filter;
    logic [10:0] thr_rx_early, thr_tx_avail, thr_tx_start;
    logic [2:0]  thr_off;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        string       req;
        int          sel;
        logic [15:0] exp;
    } item_t;
    item_t sb[$];

    localparam int S_STAT = 0, S_IRQ = 1, S_RXEN = 2, S_TXEN = 3, S_RXRST = 4,
                   S_TXRST = 5, S_FILT = 6, S_THR0 = 7, S_THR1 = 8, S_THR2 = 9,
                   S_OFF = 10;

    always #10 clk = ~clk;

    hcp_ctrl_port i_hcp_ctrl_port (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
        .evt_pulse(evt_pulse), .status(status), .irq(irq), .rx_en(rx_en),
        .tx_en(tx_en), .rx_rst(rx_rst), .tx_rst(tx_rst), .rx_filter(rx_filter),
        .thr_rx_early(thr_rx_early), .thr_tx_avail(thr_tx_avail),
        .thr_tx_start(thr_tx_start), .thr_off(thr_off)
    );

    function automatic logic [15:0] observe(int sel);
        case (sel)
            S_STAT:  return status;
            S_IRQ:   return {15'd0, irq};
            S_RXEN:  return {15'd0, rx_en};
            S_TXEN:  return {15'd0, tx_en};
            S_RXRST: return {15'd0, rx_rst};
            S_TXRST: return {15'd0, tx_rst};
            S_FILT:  return {12'd0, rx_filter};
            S_THR0:  return {5'd0, thr_rx_early};
            S_THR1:  return {5'd0, thr_tx_avail};
            S_THR2:  return {5'd0, thr_tx_start};
            default: return {13'd0, thr_off};
        endcase
    endfunction

    // Monitor: after each rising edge, compare every queued expectation
    initial forever begin
        @(posedge clk);
        #5;
        while (sb.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it  = sb.pop_front();
            act = observe(it.sel);
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic step(input logic we, input logic [4:0] op,
                        input logic [10:0] arg, input logic [7:0] ev);
        @(negedge clk);
        cmd_we    = we;
        cmd_data  = {op, arg};
        evt_pulse = ev;
    endtask

    task automatic cmd(input logic [4:0] op, input logic [10:0] arg);
        step(1'b1, op, arg, 8'h00);
    endtask

    task automatic idle();
        step(1'b0, 5'd0, 11'd0, 8'h00);
    endtask

    task automatic expect_v(input string req, input int sel, input logic [15:0] v);
        item_t it;
        it.req = req; it.sel = sel; it.exp = v;
        sb.push_back(it);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        expect_v("R12", S_STAT, 16'h0000);
        expect_v("R3", S_RXEN, 16'd0);
        expect_v("R3", S_TXEN, 16'd0);
        expect_v("R8", S_IRQ, 16'd0);

        cmd(5'd15, 11'h0FF);  expect_v("R9", S_STAT, 16'h0000);
        cmd(5'd1, 11'h7FD);   expect_v("R2", S_STAT, 16'hA000);
        cmd(5'd4, 11'h7FF);   expect_v("R1", S_RXEN, 16'd1);
                              expect_v("R1", S_STAT, 16'hA000);
        cmd(5'd9, 11'h555);   expect_v("R3", S_TXEN, 16'd1);
        cmd(5'd3, 11'h000);   expect_v("R3", S_RXEN, 16'd0);
        cmd(5'd10, 11'h000);  expect_v("R3", S_TXEN, 16'd0);
        cmd(5'd4, 11'h000);   expect_v("R3", S_RXEN, 16'd1);

        cmd(5'd5, 11'h000);   expect_v("R4", S_RXRST, 16'd1);
                              expect_v("R4", S_RXEN, 16'd1);
        idle();               expect_v("R4", S_RXRST, 16'd0);
        cmd(5'd11, 11'h000);  expect_v("R4", S_TXRST, 16'd1);
        idle();               expect_v("R4", S_TXRST, 16'd0);

        step(1'b0, 5'd0, 11'd0, 8'hFF);
        expect_v("R5", S_STAT, 16'hA0BE);
        expect_v("R8", S_IRQ, 16'd0);
        cmd(5'd13, 11'h00C);  expect_v("R7", S_STAT, 16'hA0B2);
        step(1'b1, 5'd13, 11'h010, 8'h10);
        expect_v("R7", S_STAT, 16'hA0B2);
        cmd(5'd12, 11'h000);  expect_v("R6", S_STAT, 16'hA0F2);
        cmd(5'd14, 11'h004);  expect_v("R8", S_IRQ, 16'd0);
        step(1'b0, 5'd0, 11'd0, 8'h04);
        expect_v("R8", S_STAT, 16'hA0F7);
        expect_v("R8", S_IRQ, 16'd1);
        step(1'b0, 5'd0, 11'd0, 8'h08);
        expect_v("R5", S_STAT, 16'hA0FF);
        cmd(5'd13, 11'h0FE);  expect_v("R8", S_STAT, 16'hA001);
                              expect_v("R8", S_IRQ, 16'd1);
        cmd(5'd13, 11'h001);  expect_v("R8", S_IRQ, 16'd0);
                              expect_v("R7", S_STAT, 16'hA000);

        cmd(5'd15, 11'h00F);  expect_v("R9", S_STAT, 16'hA000);
        step(1'b0, 5'd0, 11'd0, 8'h30);
        expect_v("R9", S_STAT, 16'hA000);
        cmd(5'd15, 11'h0FF);  expect_v("R9", S_STAT, 16'hA030);
        cmd(5'd13, 11'h030);  expect_v("R7", S_STAT, 16'hA000);

        cmd(5'd16, 11'h7FA);  expect_v("R10", S_FILT, 16'h000A);
        cmd(5'd17, 11'd100);  expect_v("R11", S_THR0, 16'd100);
                              expect_v("R11", S_OFF, 16'd0);
        cmd(5'd18, 11'd2047); expect_v("R11", S_THR1, 16'd2047);
                              expect_v("R11", S_OFF, 16'd2);
        cmd(5'd19, 11'd2046); expect_v("R11", S_THR2, 16'd2046);
                              expect_v("R11", S_OFF, 16'd2);

        cmd(5'd0, 11'h123);
        expect_v("R12", S_STAT, 16'h1000);
        expect_v("R12", S_RXEN, 16'd0);
        expect_v("R12", S_TXEN, 16'd0);
        expect_v("R12", S_FILT, 16'd0);
        expect_v("R12", S_THR1, 16'd0);
        expect_v("R12", S_OFF, 16'd0);
        expect_v("R12", S_IRQ, 16'd0);
        cmd(5'd4, 11'h000);   expect_v("R12", S_STAT, 16'h1000);
                              expect_v("R12", S_RXEN, 16'd0);
        idle();               expect_v("R12", S_STAT, 16'h1000);
        idle();               expect_v("R12", S_STAT, 16'h1000);
        idle();               expect_v("R12", S_STAT, 16'h0000);
        cmd(5'd4, 11'h000);   expect_v("R12", S_RXEN, 16'd1);

        cmd(5'd15, 11'h0FF);
        step(1'b0, 5'd0, 11'd0, 8'h41);
        expect_v("R5", S_STAT, 16'h0000);
        idle();
        idle();
        idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule